// File: doc/BRIEF.md
# Embedded Flash Command Sequencer

This block sits between a simple register bus and an embedded flash array. Software loads a target byte address, a data word and a command code, then starts the command through a four-bit mode handshake in the control register. The block runs one of three operations on the array: it can program a word, erase a page or erase the whole array. It then returns the mode field to its finished code. The array in this design is a behavioural model, with a parameterised word count and page size. An extra read port lets the array contents be observed.

Every command is screened before it can reach the array. An unknown command code, a target address outside the legal window, or a page that the external permit input marks as locked causes the command to be rejected. A rejected command finishes at once and leaves the array untouched. Results and errors are kept as sticky status flags. Each flag can raise the single interrupt line when its enable bit is set. Each operation type has its own parameterised busy time.

Register word index on `reg_addr`: 0 target address, 1 write data, 2 command (bits [3:0]), 3 control (mode in bits [3:0]), 4 interrupt enable (bits [4:0]), 5 status. Status layout: bit 0 finished, bit 1 bad address, bit 2 checksum error (no source in this block, always 0), bit 3 bad command, bit 4 operation error, bit 16 raw idle, bit 17 locked-page error. Unused indices and bits read as 0.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, the mode field reads 0x6 and status reads 0x0001_0000 (raw idle bit 16 set, all other bits clear). The target, data, command and enable registers read 0, every array word reads 0xFFFF_FFFF, and irq is low.
- R2: Writing 0xA to the mode field while it holds 0x6 or 0xE launches the stored command. While the command runs, the mode reads 0xA and bit 16 reads 0. The command completes after 3 (program), 6 (page erase) or 9 (mass erase) clock edges. On completion the mode becomes 0xE and finished bit 0 is set. Any other value written to the mode field is stored, and writing 0xA while the mode holds any other value is ignored.
- R3: Command 0x4 ANDs the data register into the word at target bits [7:2] (default 64-word array), so bits only fall from 1 to 0. Target bits [1:0] are ignored.
- R4: Command 0x8 sets every word of the page selected by target bits [7:5] (32-byte pages) to 0xFFFF_FFFF. The target bits below the page boundary are ignored.
- R5: Command 0xA sets every array word to 0xFFFF_FFFF, whatever the target address or page permit.
- R6: A command code other than 0x0, 0x4, 0x8 or 0xA sets status bits 3, 4 and 0. The mode goes to 0xE on the edge that commits it, and the array is unchanged.
- R7: A program or page erase whose target is 0x2000_0000 or higher sets status bits 1, 4 and 0, finishes at once, and leaves the array unchanged.
- R8: A program or page erase committed while page_ok is low (the locked page is the one on lock_page = target bits [7:5]) is skipped. It sets bit 17, bit 4 and bit 0. Bit 17 is cleared when the next command is committed.
- R9: Status bits [4:0] are sticky. Writing 0 to one of them clears it, and writing 1 leaves it unchanged. If a completion sets a flag on the same edge that software clears it, the flag ends up set.
- R10: irq is high exactly when some status bit in [4:0] is set and the matching enable bit is set.
- R11: While a command runs, writes to the target, data, command and control registers are ignored. Writes to the enable and status registers still take effect.
- R12: Committing command 0x0 changes no array word and sets only finished bit 0, with mode 0xE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| lock_page | output | 3 | Page index of the current target, for the permit lookup |
| page_ok | input | 1 | High when the page on lock_page may be altered |
| irq | output | 1 | Interrupt request |
| peek_idx | input | 6 | Array word index for the observation port |
| peek_data | output | 32 | Array word at peek_idx |

## Verification
Two things can land on the same clock edge: a running command reaching its end, which sets the finished flag, and a software write to the status register that clears that same flag. The bench first clears the finished flag. It then launches a mass erase and times a status write carrying 0 in bit 0 so that it lands on the exact completion edge. The reference model applies the clear first and the set afterwards, so the flag must read 1 afterwards. A second overlap occurs when target, command and control writes fall inside a busy window. The reference model discards these writes, and the register readback and the array contents must show no trace of them.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam logic [3:0] MODE_IDLE = 4'h6;
    localparam logic [3:0] MODE_GO   = 4'hA;
    localparam logic [3:0] MODE_DONE = 4'hE;

    localparam logic [3:0] CMD_NONE = 4'h0;
    localparam logic [3:0] CMD_WORD = 4'h4;
    localparam logic [3:0] CMD_PAGE = 4'h8;
    localparam logic [3:0] CMD_BULK = 4'hA;

    localparam logic [2:0] RI_TGT  = 3'd0;
    localparam logic [2:0] RI_DAT  = 3'd1;
    localparam logic [2:0] RI_CMD  = 3'd2;
    localparam logic [2:0] RI_CTRL = 3'd3;
    localparam logic [2:0] RI_IEN  = 3'd4;
    localparam logic [2:0] RI_STAT = 3'd5;

    localparam int FB_FIN  = 0;
    localparam int FB_ADDR = 1;
    localparam int FB_SUM  = 2;
    localparam int FB_CMD  = 3;
    localparam int FB_ERR  = 4;

    typedef enum logic [1:0] {
        ARR_HOLD,
        ARR_WORD,
        ARR_PAGE,
        ARR_BULK
    } arr_op_e;

    typedef enum logic [2:0] {
        VD_RUN,
        VD_NOP,
        VD_BADCMD,
        VD_BADADDR,
        VD_LOCKED
    } verdict_e;

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
    import fcs_pkg::*;
(
    input  logic [3:0] cmd,
    input  logic [2:0] tgt_hi,
    input  logic       page_ok,
    output verdict_e   verdict,
    output arr_op_e    op
);

    always_comb begin
        op      = ARR_HOLD;
        verdict = VD_NOP;
        case (cmd)
            CMD_NONE: verdict = VD_NOP;
            CMD_WORD: op = ARR_WORD;
            CMD_PAGE: op = ARR_PAGE;
            CMD_BULK: op = ARR_BULK;
            default:  verdict = VD_BADCMD;
        endcase
        if (op != ARR_HOLD) begin
            verdict = VD_RUN;
            if (op != ARR_BULK) begin
                if (tgt_hi != 3'b000) begin
                    verdict = VD_BADADDR;
                end else if (!page_ok) begin
                    verdict = VD_LOCKED;
                end
            end
        end
    end

endmodule

// File: rtl/fcs_array.sv
module fcs_array
    import fcs_pkg::*;
#(
    parameter int WORDS      = 64,
    parameter int PAGE_WORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  arr_op_e                  op,
    input  logic [$clog2(WORDS)-1:0] word_idx,
    input  logic [31:0]              wdata,
    input  logic [$clog2(WORDS)-1:0] rd_idx,
    output logic [31:0]              rd_data
);

    localparam int IW = $clog2(WORDS);
    localparam int PB = $clog2(PAGE_WORDS);

    logic [31:0] rows [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_cell
        localparam logic [IW-1:0] GI = IW'(g);
        logic [31:0] cell_q;
        logic        same_page;

        assign same_page = (word_idx[IW-1:PB] == GI[IW-1:PB]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '1;
            end else begin
                case (op)
                    ARR_WORD: if (word_idx == GI) cell_q <= cell_q & wdata;
                    ARR_PAGE: if (same_page) cell_q <= '1;
                    ARR_BULK: cell_q <= '1;
                    default:  cell_q <= cell_q;
                endcase
            end
        end

        assign rows[g] = cell_q;
    end

    assign rd_data = rows[rd_idx];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ARRAY_WORDS = 64,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 3,
    parameter int PAGE_CYCLES = 6,
    parameter int BULK_CYCLES = 9,
    localparam int IW         = $clog2(ARRAY_WORDS),
    localparam int PG_W       = IW + 2 - $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic [PG_W-1:0] lock_page,
    input  logic            page_ok,
    output logic            irq,
    input  logic [IW-1:0]   peek_idx,
    output logic [31:0]     peek_data
);

    localparam int PAGE_WORDS = PAGE_BYTES / 4;
    localparam int BYTE_AW    = IW + 2;
    localparam int PAGE_SH    = $clog2(PAGE_BYTES);
    localparam int MAX_LAT    = (BULK_CYCLES > PAGE_CYCLES)
                              ? ((BULK_CYCLES > PROG_CYCLES) ? BULK_CYCLES : PROG_CYCLES)
                              : ((PAGE_CYCLES > PROG_CYCLES) ? PAGE_CYCLES : PROG_CYCLES);
    localparam int CW         = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic [31:0]   tgt;
        logic [31:0]   wdat;
        logic [3:0]    cmd;
        logic [3:0]    mode;
        logic [4:0]    ien;
        logic [4:0]    flg;
        logic          perr;
        logic          busy;
        logic [CW-1:0] cnt;
        arr_op_e       op;
    } st_t;

    st_t      st_q, st_d;
    verdict_e dec_verdict;
    arr_op_e  dec_op;
    arr_op_e  arr_go;
    logic     fire;
    logic     commit;

    fcs_decode u_dec (
        .cmd     (st_q.cmd),
        .tgt_hi  (st_q.tgt[31:29]),
        .page_ok (page_ok),
        .verdict (dec_verdict),
        .op      (dec_op)
    );

    fcs_array #(
        .WORDS      (ARRAY_WORDS),
        .PAGE_WORDS (PAGE_WORDS)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (arr_go),
        .word_idx (st_q.tgt[IW+1:2]),
        .wdata    (st_q.wdat),
        .rd_idx   (peek_idx),
        .rd_data  (peek_data)
    );

    assign fire   = st_q.busy && (st_q.cnt == '0);
    assign arr_go = fire ? st_q.op : ARR_HOLD;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;

        // bus writes; command-path registers are frozen while busy
        if (reg_wr) begin
            case (reg_addr)
                RI_TGT:  if (!st_q.busy) st_d.tgt  = reg_wdata;
                RI_DAT:  if (!st_q.busy) st_d.wdat = reg_wdata;
                RI_CMD:  if (!st_q.busy) st_d.cmd  = reg_wdata[3:0];
                RI_CTRL: begin
                    if (!st_q.busy) begin
                        if (reg_wdata[3:0] == MODE_GO) begin
                            commit = (st_q.mode == MODE_IDLE) || (st_q.mode == MODE_DONE);
                        end else begin
                            st_d.mode = reg_wdata[3:0];
                        end
                    end
                end
                RI_IEN:  st_d.ien = reg_wdata[4:0];
                RI_STAT: st_d.flg = st_q.flg & reg_wdata[4:0];
                default: ;
            endcase
        end

        if (commit) begin
            st_d.perr = 1'b0;
            case (dec_verdict)
                VD_RUN: begin
                    st_d.busy = 1'b1;
                    st_d.mode = MODE_GO;
                    st_d.op   = dec_op;
                    case (dec_op)
                        ARR_WORD: st_d.cnt = CW'(PROG_CYCLES - 1);
                        ARR_PAGE: st_d.cnt = CW'(PAGE_CYCLES - 1);
                        default:  st_d.cnt = CW'(BULK_CYCLES - 1);
                    endcase
                end
                VD_BADCMD: begin
                    st_d.mode         = MODE_DONE;
                    st_d.flg[FB_CMD]  = 1'b1;
                    st_d.flg[FB_ERR]  = 1'b1;
                    st_d.flg[FB_FIN]  = 1'b1;
                end
                VD_BADADDR: begin
                    st_d.mode         = MODE_DONE;
                    st_d.flg[FB_ADDR] = 1'b1;
                    st_d.flg[FB_ERR]  = 1'b1;
                    st_d.flg[FB_FIN]  = 1'b1;
                end
                VD_LOCKED: begin
                    st_d.mode         = MODE_DONE;
                    st_d.perr         = 1'b1;
                    st_d.flg[FB_ERR]  = 1'b1;
                    st_d.flg[FB_FIN]  = 1'b1;
                end
                default: begin
                    st_d.mode         = MODE_DONE;
                    st_d.flg[FB_FIN]  = 1'b1;
                end
            endcase
        end

        // running command: count down, finish after the software clear so set wins
        if (st_q.busy) begin
            if (fire) begin
                st_d.busy        = 1'b0;
                st_d.op          = ARR_HOLD;
                st_d.mode        = MODE_DONE;
                st_d.flg[FB_FIN] = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_IDLE;
            st_q.op   <= ARR_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RI_TGT:  reg_rdata = st_q.tgt;
            RI_DAT:  reg_rdata = st_q.wdat;
            RI_CMD:  reg_rdata[3:0] = st_q.cmd;
            RI_CTRL: reg_rdata[3:0] = st_q.mode;
            RI_IEN:  reg_rdata[4:0] = st_q.ien;
            RI_STAT: begin
                reg_rdata[4:0] = st_q.flg;
                reg_rdata[16]  = ~st_q.busy;
                reg_rdata[17]  = st_q.perr;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign lock_page = st_q.tgt[BYTE_AW-1:PAGE_SH];
    assign irq       = |(st_q.flg & st_q.ien);

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        busy,
    input logic [3:0]  mode,
    input logic [31:0] tgt,
    input logic        perr,
    input logic        fin
);

    assert_launch_needs_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == 3'd3 && reg_wdata[3:0] == 4'hA
                              && (mode == 4'h6 || mode == 4'hE)));

    assert_busy_shows_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mode == 4'hA);

    assert_finish_marks_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (mode == 4'hE && fin));

    assert_target_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tgt));

    assert_lock_rejects_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr) |-> (mode == 4'hE && !busy));

    assert_lock_flag_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !perr);

endmodule

bind flash_cmd_seq fcs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (st_q.busy),
    .mode      (st_q.mode),
    .tgt       (st_q.tgt),
    .perr      (st_q.perr),
    .fin       (st_q.flg[0])
);

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;

    localparam int PL = 3;
    localparam int EL = 6;
    localparam int ML = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd5;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  lock_page;
    logic        page_ok;
    logic        irq;
    logic [5:0]  peek_idx = '0;
    logic [31:0] peek_data;
    logic [7:0]  lockmask = '0;

    int vectors = 0;
    int misses  = 0;
    string phase = "R1 reset state";

    always #2 clk = ~clk;

    assign page_ok = ~lockmask[lock_page];

    flash_cmd_seq #(
        .ARRAY_WORDS (64),
        .PAGE_BYTES  (32),
        .PROG_CYCLES (PL),
        .PAGE_CYCLES (EL),
        .BULK_CYCLES (ML)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lock_page (lock_page),
        .page_ok   (page_ok),
        .irq       (irq),
        .peek_idx  (peek_idx),
        .peek_data (peek_data)
    );

    // behavioural reference model
    logic [31:0] m_tgt, m_wd, m_mem [64];
    logic [3:0]  m_cmd, m_mode, m_op;
    logic [4:0]  m_ien, m_flg;
    logic        m_pe, m_busy, m_ready = 1'b0, b0;
    int          m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tgt = 0; m_wd = 0; m_cmd = 0; m_mode = 4'h6; m_ien = 0; m_flg = 0;
            m_pe = 0; m_busy = 0; m_cnt = 0; m_op = 0;
            for (int k = 0; k < 64; k++) m_mem[k] = 32'hFFFF_FFFF;
            m_ready = 1'b1;
        end else begin
            b0 = m_busy;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: if (!b0) m_tgt = reg_wdata;
                    3'd1: if (!b0) m_wd = reg_wdata;
                    3'd2: if (!b0) m_cmd = reg_wdata[3:0];
                    3'd3: if (!b0) begin
                        if (reg_wdata[3:0] == 4'hA) begin
                            if (m_mode == 4'h6 || m_mode == 4'hE) begin
                                m_pe = 0;
                                if (!(m_cmd inside {4'h0, 4'h4, 4'h8, 4'hA})) begin
                                    m_flg = m_flg | 5'b11001; m_mode = 4'hE;
                                end else if (m_cmd == 4'h0) begin
                                    m_flg[0] = 1; m_mode = 4'hE;
                                end else if (m_cmd != 4'hA && m_tgt >= 32'h2000_0000) begin
                                    m_flg = m_flg | 5'b10011; m_mode = 4'hE;
                                end else if (m_cmd != 4'hA && lockmask[m_tgt[7:5]]) begin
                                    m_pe = 1; m_flg = m_flg | 5'b10001; m_mode = 4'hE;
                                end else begin
                                    m_busy = 1; m_mode = 4'hA; m_op = m_cmd;
                                    m_cnt = (m_cmd == 4'h4) ? PL - 1 : (m_cmd == 4'h8) ? EL - 1 : ML - 1;
                                end
                            end
                        end else begin
                            m_mode = reg_wdata[3:0];
                        end
                    end
                    3'd4: m_ien = reg_wdata[4:0];
                    3'd5: m_flg = m_flg & reg_wdata[4:0];
                    default: ;
                endcase
            end
            if (b0) begin
                if (m_cnt == 0) begin
                    if (m_op == 4'h4) m_mem[m_tgt[7:2]] = m_mem[m_tgt[7:2]] & m_wd;
                    else if (m_op == 4'h8) begin
                        for (int k = 0; k < 8; k++) m_mem[{m_tgt[7:5], 3'(k)}] = 32'hFFFF_FFFF;
                    end else begin
                        for (int k = 0; k < 64; k++) m_mem[k] = 32'hFFFF_FFFF;
                    end
                    m_busy = 0; m_mode = 4'hE; m_flg[0] = 1;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
        end
    end

    function automatic logic [31:0] exp_reg(input logic [2:0] a);
        logic [31:0] r = '0;
        case (a)
            3'd0: r = m_tgt;
            3'd1: r = m_wd;
            3'd2: r[3:0] = m_cmd;
            3'd3: r[3:0] = m_mode;
            3'd4: r[4:0] = m_ien;
            3'd5: begin r[4:0] = m_flg; r[16] = ~m_busy; r[17] = m_pe; end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && m_ready) begin
            check("register readback", reg_rdata, exp_reg(reg_addr));
            check("irq (R10)", {31'd0, irq}, {31'd0, |(m_flg & m_ien)});
            check("array word", peek_data, m_mem[peek_idx]);
            check("lock_page", {29'd0, lock_page}, {29'd0, m_tgt[7:5]});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 3'd5;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic launch(input logic [3:0] c, input logic [31:0] t, input logic [31:0] d);
        wr(3'd0, t); wr(3'd1, d); wr(3'd2, {28'd0, c}); wr(3'd3, 32'hA);
    endtask

    task automatic scan();
        for (int i = 0; i < 64; i++) begin
            @(posedge clk); #1; peek_idx = 6'(i);
        end
    endtask

    task automatic read_all();
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1; reg_addr = 3'(i);
        end
        @(posedge clk); #1; reg_addr = 3'd5;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        idle(3); #1; rst_n = 1'b1;
        phase = "R1 reset state";
        read_all(); scan();

        phase = "R3 word program with low address bits";
        launch(4'h4, 32'h0000_0013, 32'hF0F0_1234); idle(8); scan();
        phase = "R3 second program ANDs bits";
        launch(4'h4, 32'h0000_0010, 32'h0FFF_FF0F); idle(8); read_all(); scan();

        phase = "R4 page erase ignores low bits";
        launch(4'h4, 32'h0000_0024, 32'h1234_5678); idle(8);
        launch(4'h4, 32'h0000_003C, 32'h0000_0000); idle(8);
        launch(4'h4, 32'h0000_0040, 32'hAAAA_0000); idle(8);
        launch(4'h8, 32'h0000_002B, 32'h0); idle(12); scan();

        phase = "R8 locked page skipped";
        lockmask = 8'b0000_0100;
        launch(4'h4, 32'h0000_0044, 32'h0000_0000); idle(4); read_all(); scan();
        phase = "R12 idle command clears R8 flag";
        launch(4'h0, 32'h0000_0044, 32'h0); idle(4); read_all(); scan();

        phase = "R6 unknown command code";
        launch(4'h5, 32'h0000_0000, 32'h0); idle(4); read_all(); scan();
        phase = "R7 target out of range";
        wr(3'd5, 32'h0);
        launch(4'h4, 32'h2000_0010, 32'h0); idle(4); read_all();
        launch(4'h8, 32'hFFFF_FFFC, 32'h0); idle(4); read_all(); scan();

        phase = "R10 interrupt enables";
        wr(3'd4, 32'h0000_0002); idle(2);
        wr(3'd4, 32'h0000_0004); idle(2);
        wr(3'd4, 32'h0000_001F); idle(2);
        phase = "R9 write zero clears, one keeps";
        wr(3'd5, 32'h0000_0015); idle(2); read_all();
        wr(3'd5, 32'h0000_0000); idle(2); read_all();

        phase = "R2 mode handshake";
        wr(3'd3, 32'h3); idle(1);
        wr(3'd0, 32'h0000_0008); wr(3'd1, 32'h0); wr(3'd2, 32'h4);
        wr(3'd3, 32'hA); idle(6); read_all(); scan();
        wr(3'd3, 32'h6); idle(1);
        launch(4'h4, 32'h0000_0008, 32'h0000_FFFF); idle(8); read_all(); scan();

        phase = "R11 writes ignored while busy";
        launch(4'h4, 32'h0000_0050, 32'h00FF_00FF);
        wr(3'd0, 32'h0000_0060); wr(3'd2, 32'h8);
        idle(6); read_all(); scan();
        launch(4'h8, 32'h0000_0040, 32'h0);
        wr(3'd0, 32'h0000_0000); wr(3'd1, 32'h5); wr(3'd3, 32'h6); wr(3'd3, 32'hA);
        wr(3'd4, 32'h1);
        idle(8); read_all(); scan();

        phase = "R9 clear collides with completion";
        lockmask = 8'hFF;
        wr(3'd5, 32'h0000_001E); idle(1);
        launch(4'h0, 32'h0, 32'h0); idle(2);
        wr(3'd5, 32'h0000_001E); idle(1);
        wr(3'd0, 32'h0000_0020); wr(3'd1, 32'h0); wr(3'd2, 32'hA);
        wr(3'd3, 32'hA);
        idle(ML - 2);
        wr(3'd5, 32'h0000_001E); idle(2); read_all();
        phase = "R5 mass erase ignores locks";
        scan();

        idle(4);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

endmodule